// File: doc/BRIEF.md
# Dual-FIFO Character Buffer with Threshold Interrupts

This block is a character buffer between a processor and a host-side agent. It has two byte FIFOs. The processor writes characters into the transmit FIFO through a small register window, and the host side takes them out one pop at a time. The host side pushes characters into the receive FIFO, and the processor removes them by reading the data register.

Both FIFOs have occupancy counters. Each counter feeds a pending condition with a fixed threshold. The transmit condition asks for more characters when the transmit FIFO runs low. The receive condition asks for service when the receive FIFO nears full. It also fires when the host says no more characters are coming and at least one character is still waiting. Two enable bits gate the conditions onto one level-sensitive interrupt line. The raw conditions can always be read in a status word, together with the receive occupancy and the transmit free space, so software can size its bursts.

The thresholds and the FIFO depth are elaboration-time parameters. Elaboration fails if the depth is not a power of two between 2 and 128, or if either threshold is not below the depth.

Top module: `dual_fifo_irq_ctrl`

## Requirements
- R1: After reset, both FIFOs are empty, both enable bits are 0, `irq` is 0, `host_tx_valid` is 0 and `reg_rdata` is 0.
- R2: A register write to address 0 pushes `reg_wdata` into the transmit FIFO. A `host_tx_pop` returns the oldest character on `host_tx_data`, with `host_tx_valid`=1, in the cycle after the pop. A pop from an empty transmit FIFO gives `host_tx_valid`=0.
- R3: A `host_rx_push` stores `host_rx_data` in the receive FIFO. A register read of address 0 pops it, and in the next cycle `reg_rdata[7:0]` holds the character and `reg_rdata[15]` is 1. A read from an empty receive FIFO returns bit 15 = 0 and leaves the occupancy unchanged.
- R4: A push into a full FIFO is discarded. If a push and a pop arrive in the same cycle on a full FIFO, only the pop takes effect. If they arrive together on an empty FIFO, only the push takes effect, and the pop reports no valid character.
- R5: The transmit pending flag is 1 whenever the transmit occupancy is WR_THR or less. Only pushes that raise the occupancy above WR_THR can clear it.
- R6: The receive pending flag is 1 whenever the receive FIFO has RD_THR or fewer free entries.
- R7: The receive pending flag is also 1 when `host_eos` is 1 and the receive FIFO holds at least one character.
- R8: Address 1 is the control register. Bit 0 enables the transmit interrupt and bit 1 enables the receive interrupt. A read of address 1 returns both bits in the next cycle.
- R9: `irq` = (bit 0 of control AND transmit pending) OR (bit 1 of control AND receive pending).
- R10: A read of address 2 returns, in the next cycle:
  - bit 0: transmit pending
  - bit 1: receive pending
  - bits [15:8]: receive occupancy
  - bits [23:16]: transmit free space

  These values are the ones present when the read is issued. The pending bits are shown whatever the enables are. Writes to addresses 2 and 3 have no effect, and reads of address 3 return 0.
- R11: The pending flags and `irq` follow the registered occupancy counts. They change in the cycle after the push or pop that changes a count, and in the same cycle as a change on `host_eos`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 data, 1 control, 2 status, 3 unused) |
| reg_wdata | input | 8 | Write data (character, or the control bits) |
| reg_rdata | output | 32 | Read data, valid in the cycle after `reg_rd` |
| host_tx_pop | input | 1 | Host takes one character from the transmit FIFO |
| host_tx_data | output | 8 | Character taken by the previous pop |
| host_tx_valid | output | 1 | The previous pop returned a character |
| host_rx_push | input | 1 | Host stores one character in the receive FIFO |
| host_rx_data | input | 8 | Character to store |
| host_eos | input | 1 | Host expects to send no more characters |
| irq | output | 1 | Combined level-sensitive interrupt |

## Verification
The hardest states to reach from the ports lie at the edges of the FIFOs:
- a receive FIFO that is full, or within one entry of the threshold boundary, while `host_eos` changes;
- a same-cycle push and pop on a FIFO that is full or empty.

Uniform random stimulus rarely gets there, because pushes and pops cancel out. The bench therefore runs random phases, each biased toward filling or draining one FIFO, so the occupancy walks to each end and stays there. Before the random phases, directed sequences step each FIFO one character at a time across its threshold and past full and empty.

// File: rtl/dfic_pkg.sv
`timescale 1ns/1ps
// Package: shared register map constants and types for the dual-FIFO
// interrupt controller. Assumes a 32-bit read word and 8-bit characters.
package dfic_pkg;
    localparam int CHAR_W          = 8;
    localparam int REG_W           = 32;

    // Bit positions inside the control word.
    localparam int CTRL_TX_EN_BIT  = 0;
    localparam int CTRL_RX_EN_BIT  = 1;

    // Bit positions inside the status word.
    localparam int STAT_TX_PEND    = 0;
    localparam int STAT_RX_PEND    = 1;
    localparam int STAT_RX_CNT_LSB = 8;
    localparam int STAT_TX_FREE_LSB = 16;

    // Flag telling that a data-register read returned a character.
    localparam int RD_VALID_BIT    = 15;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } dfic_addr_e;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
    } dfic_ctrl_t;
endpackage

// File: rtl/dfic_fifo.sv
`timescale 1ns/1ps
// Module: dfic_fifo
// Synchronous single-clock FIFO with an occupancy count.
// A push into a full FIFO is dropped. A pop from an empty FIFO sets
// pop_valid to 0. When both arrive together, each is judged on the count
// before the edge. Popped data is registered and appears one cycle after
// the pop. Assumes DEPTH is a power of two.
module dfic_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic          pop_valid,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          push_ok;
    logic          pop_ok;

    // Accept a push or pop only when it is legal for the current count.
    always_comb begin
        push_ok = push && (count != FULL_CNT);
        pop_ok  = pop  && (count != '0);
    end

    // Storage write; the array needs no reset.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                wptr <= wptr + 1'b1;
            end
            if (pop_ok) begin
                rptr <= rptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Registered pop output with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_data  <= '0;
            pop_valid <= 1'b0;
        end else begin
            pop_valid <= pop_ok;
            if (pop_ok) begin
                pop_data <= mem[rptr];
            end
        end
    end
endmodule

// File: rtl/dfic_pending.sv
`timescale 1ns/1ps
// Module: dfic_pending
// Works out the two pending conditions from the registered occupancy
// counts and the end-of-stream level, then gates them with the enables
// into one interrupt. Purely combinational. Assumes both thresholds are
// below DEPTH.
module dfic_pending #(
    parameter int DEPTH  = 16,
    parameter int WR_THR = 8,
    parameter int RD_THR = 8,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic          eos,
    input  logic          en_tx,
    input  logic          en_rx,
    output logic          tx_pend,
    output logic          rx_pend,
    output logic          irq
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] WR_LIM   = CW'(WR_THR);
    localparam logic [CW-1:0] RD_LIM   = CW'(RD_THR);

    logic [CW-1:0] rx_free;

    // Low-water test on transmit, high-water and end-of-stream on receive.
    always_comb begin
        rx_free = FULL_CNT - rx_count;
        tx_pend = (tx_count <= WR_LIM);
        rx_pend = (rx_free <= RD_LIM) || (eos && (rx_count != '0));
    end

    // Combine the gated conditions into the interrupt line.
    always_comb begin
        irq = (en_tx && tx_pend) || (en_rx && rx_pend);
    end
endmodule

// File: rtl/dfic_regif.sv
`timescale 1ns/1ps
// Module: dfic_regif
// Processor-side register window: decodes the strobes into FIFO
// push and pop, holds the control bits, and forms the read word one
// cycle after a read. A data read takes its word from the receive
// FIFO's registered output; control and status reads are captured at
// the read edge. Assumes DEPTH <= 128, so that a count fits in 8 bits.
module dfic_regif
    import dfic_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [CHAR_W-1:0] reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              tx_pend,
    input  logic              rx_pend,
    input  logic [CW-1:0]     tx_count,
    input  logic [CW-1:0]     rx_count,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_char_valid,
    output logic              tx_push,
    output logic              rx_pop,
    output logic              en_tx,
    output logic              en_rx
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    dfic_addr_e       addr;
    dfic_ctrl_t       ctrl_q;
    logic [REG_W-1:0] stat_word;
    logic [REG_W-1:0] hold_q;
    logic             sel_data_q;
    logic [CW-1:0]    tx_free;

    // Decode the strobes into FIFO operations.
    always_comb begin
        addr    = dfic_addr_e'(reg_addr);
        tx_push = reg_wr && (addr == ADDR_DATA);
        rx_pop  = reg_rd && (addr == ADDR_DATA);
        en_tx   = ctrl_q.tx_en;
        en_rx   = ctrl_q.rx_en;
    end

    // Put the status fields together from the live conditions and counts.
    always_comb begin
        tx_free   = FULL_CNT - tx_count;
        stat_word = '0;
        stat_word[STAT_TX_PEND] = tx_pend;
        stat_word[STAT_RX_PEND] = rx_pend;
        stat_word[STAT_RX_CNT_LSB +: CW]  = rx_count;
        stat_word[STAT_TX_FREE_LSB +: CW] = tx_free;
    end

    // Control register holding the two enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && (addr == ADDR_CTRL)) begin
            ctrl_q.tx_en <= reg_wdata[CTRL_TX_EN_BIT];
            ctrl_q.rx_en <= reg_wdata[CTRL_RX_EN_BIT];
        end
    end

    // Capture the word for a control or status read; mark a data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            sel_data_q <= 1'b0;
        end else begin
            sel_data_q <= rx_pop;
            hold_q     <= '0;
            if (reg_rd) begin
                case (addr)
                    ADDR_CTRL: begin
                        hold_q[CTRL_TX_EN_BIT] <= ctrl_q.tx_en;
                        hold_q[CTRL_RX_EN_BIT] <= ctrl_q.rx_en;
                    end
                    ADDR_STAT: hold_q <= stat_word;
                    default:   hold_q <= '0;
                endcase
            end
        end
    end

    // Choose the read word from the FIFO output or the captured value.
    always_comb begin
        reg_rdata = hold_q;
        if (sel_data_q) begin
            reg_rdata = '0;
            reg_rdata[CHAR_W-1:0]  = rx_char;
            reg_rdata[RD_VALID_BIT] = rx_char_valid;
        end
    end
endmodule

// File: rtl/dual_fifo_irq_ctrl.sv
`timescale 1ns/1ps
// Module: dual_fifo_irq_ctrl
// Top level of the character buffer. The transmit FIFO is filled from the
// register window and emptied by the host. The receive FIFO is filled by
// the host and emptied by register reads. Fixed thresholds on the two
// occupancies drive the gated interrupt. Assumes one clock domain; the
// parameter limits are enforced at elaboration.
module dual_fifo_irq_ctrl
    import dfic_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WR_THR = 8,
    parameter int RD_THR = 8,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [CHAR_W-1:0] reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              host_tx_pop,
    output logic [CHAR_W-1:0] host_tx_data,
    output logic              host_tx_valid,
    input  logic              host_rx_push,
    input  logic [CHAR_W-1:0] host_rx_data,
    input  logic              host_eos,
    output logic              irq
);
    // Parameter checks made at elaboration.
    if ((DEPTH < 2) || (DEPTH > 128) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
        $error("DEPTH must be a power of two from 2 to 128");
    end
    if ((WR_THR < 0) || (WR_THR >= DEPTH)) begin : g_bad_wr_thr
        $error("WR_THR must be below DEPTH");
    end
    if ((RD_THR < 0) || (RD_THR >= DEPTH)) begin : g_bad_rd_thr
        $error("RD_THR must be below DEPTH");
    end

    logic              tx_push;
    logic              rx_pop;
    logic              en_tx;
    logic              en_rx;
    logic              tx_pend;
    logic              rx_pend;
    logic [CW-1:0]     tx_count;
    logic [CW-1:0]     rx_count;
    logic [CHAR_W-1:0] rx_char;
    logic              rx_char_valid;

    dfic_regif #(.DEPTH(DEPTH)) regif_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .tx_pend       (tx_pend),
        .rx_pend       (rx_pend),
        .tx_count      (tx_count),
        .rx_count      (rx_count),
        .rx_char       (rx_char),
        .rx_char_valid (rx_char_valid),
        .tx_push       (tx_push),
        .rx_pop        (rx_pop),
        .en_tx         (en_tx),
        .en_rx         (en_rx)
    );

    dfic_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) tx_fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (reg_wdata),
        .pop       (host_tx_pop),
        .pop_data  (host_tx_data),
        .pop_valid (host_tx_valid),
        .count     (tx_count)
    );

    dfic_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) rx_fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (host_rx_push),
        .push_data (host_rx_data),
        .pop       (rx_pop),
        .pop_data  (rx_char),
        .pop_valid (rx_char_valid),
        .count     (rx_count)
    );

    dfic_pending #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR)) pending_i (
        .tx_count (tx_count),
        .rx_count (rx_count),
        .eos      (host_eos),
        .en_tx    (en_tx),
        .en_rx    (en_rx),
        .tx_pend  (tx_pend),
        .rx_pend  (rx_pend),
        .irq      (irq)
    );
endmodule

// File: rtl/dfic_chk.sv
`timescale 1ns/1ps
// Module: dfic_chk
// Temporal checks on the controller, bound to the top level. They relate
// the strobes, the occupancy counts, the pending flags and the interrupt
// across cycles.
module dfic_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [1:0]    reg_addr,
    input logic          host_tx_pop,
    input logic          host_tx_valid,
    input logic          host_rx_push,
    input logic          host_eos,
    input logic          rd_valid,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          tx_pend,
    input logic          rx_pend,
    input logic          en_tx,
    input logic          en_rx,
    input logic          irq
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic data_wr;
    logic data_rd;

    // Strobes aimed at the data register.
    always_comb begin
        data_wr = reg_wr && (reg_addr == 2'd0);
        data_rd = reg_rd && (reg_addr == 2'd0);
    end

    a_r4_tx_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == FULL_CNT) && data_wr && !host_tx_pop |=> (tx_count == FULL_CNT));

    a_r4_rx_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == FULL_CNT) && host_rx_push && !data_rd |=> (rx_count == FULL_CNT));

    a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) && data_rd |=> !rd_valid);

    a_r3_empty_read_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) && data_rd && !host_rx_push |=> (rx_count == '0));

    a_r2_empty_tx_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) && host_tx_pop |=> !host_tx_valid);

    a_r5_tx_clear_by_push: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_pend) |-> $past(data_wr));

    a_r6_rx_clear_by_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_pend) |-> ($past(data_rd) || $fell(host_eos)));

    a_r7_eos_irq: assert property (@(posedge clk) disable iff (!rst_n)
        en_rx && host_eos && (rx_count != '0) |-> irq);

    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_tx && !en_rx |-> !irq);
endmodule

bind dual_fifo_irq_ctrl dfic_chk #(.DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .host_tx_pop   (host_tx_pop),
    .host_tx_valid (host_tx_valid),
    .host_rx_push  (host_rx_push),
    .host_eos      (host_eos),
    .rd_valid      (reg_rdata[15]),
    .tx_count      (tx_count),
    .rx_count      (rx_count),
    .tx_pend       (tx_pend),
    .rx_pend       (rx_pend),
    .en_tx         (en_tx),
    .en_rx         (en_rx),
    .irq           (irq)
);

// File: tb/dual_fifo_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for dual_fifo_irq_ctrl. Queue models predict every output.
// Directed corner sequences run first, then biased random phases from a
// fixed seed.
module dual_fifo_irq_ctrl_tb_top;
    localparam int DEPTH  = 16;
    localparam int WR_THR = 8;
    localparam int RD_THR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [31:0] reg_rdata;
    logic        host_tx_pop = 1'b0;
    logic [7:0]  host_tx_data;
    logic        host_tx_valid;
    logic        host_rx_push = 1'b0;
    logic [7:0]  host_rx_data = 8'd0;
    logic        host_eos = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit m_en_tx = 1'b0;
    bit m_en_rx = 1'b0;

    always #10 clk = ~clk;

    dual_fifo_irq_ctrl #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .host_tx_pop   (host_tx_pop),
        .host_tx_data  (host_tx_data),
        .host_tx_valid (host_tx_valid),
        .host_rx_push  (host_rx_push),
        .host_rx_data  (host_rx_data),
        .host_eos      (host_eos),
        .irq           (irq)
    );

    function automatic bit exp_tx_pend(int n);
        return n <= WR_THR;
    endfunction

    function automatic bit exp_rx_pend(int n, bit eos);
        return ((DEPTH - n) <= RD_THR) || (eos && (n > 0));
    endfunction

    function automatic bit exp_irq(int ntx, int nrx, bit eos, bit etx, bit erx);
        return (etx && exp_tx_pend(ntx)) || (erx && exp_rx_pend(nrx, eos));
    endfunction

    function automatic logic [31:0] exp_status(int ntx, int nrx, bit eos);
        logic [31:0] w = '0;
        w[0]     = exp_tx_pend(ntx);
        w[1]     = exp_rx_pend(nrx, eos);
        w[15:8]  = 8'(nrx);
        w[23:16] = 8'(DEPTH - ntx);
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock of stimulus. The model is updated from the pre-edge state,
    // and the outputs are checked just after the edge.
    task automatic step(input bit wr, input bit rd, input logic [1:0] addr, input logic [7:0] wd,
                        input bit hpop, input bit hpush, input logic [7:0] hd, input bit eos);
        int ntx;
        int nrx;
        bit tv;
        bit rv;
        logic [7:0] tb;
        logic [7:0] rb;
        logic [31:0] exp_rd;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd;
        host_tx_pop = hpop; host_rx_push = hpush; host_rx_data = hd; host_eos = eos;
        ntx = txq.size();
        nrx = rxq.size();
        tv = 1'b0; rv = 1'b0; tb = '0; rb = '0;
        exp_rd = '0;
        if (rd && addr == 2'd1) exp_rd = {30'd0, m_en_rx, m_en_tx};
        if (rd && addr == 2'd2) exp_rd = exp_status(ntx, nrx, eos);
        if (hpop && ntx > 0) begin tv = 1'b1; tb = txq.pop_front(); end
        if (wr && addr == 2'd0 && ntx < DEPTH) txq.push_back(wd);
        if (rd && addr == 2'd0 && nrx > 0) begin rv = 1'b1; rb = rxq.pop_front(); end
        if (hpush && nrx < DEPTH) rxq.push_back(hd);
        if (wr && addr == 2'd1) begin m_en_tx = wd[0]; m_en_rx = wd[1]; end
        @(posedge clk);
        #2;
        if (hpop) begin
            check(host_tx_valid == tv, "R2/R4 tx valid", 32'(host_tx_valid), 32'(tv));
            if (tv) check(host_tx_data == tb, "R2 tx data", 32'(host_tx_data), 32'(tb));
        end
        if (rd && addr == 2'd0) begin
            check(reg_rdata[15] == rv, "R3/R4 rx valid", 32'(reg_rdata[15]), 32'(rv));
            if (rv) check(reg_rdata[7:0] == rb, "R3 rx data", 32'(reg_rdata[7:0]), 32'(rb));
        end
        if (rd && addr == 2'd1) check(reg_rdata == exp_rd, "R8 ctrl read", reg_rdata, exp_rd);
        if (rd && addr >= 2'd2) check(reg_rdata == exp_rd, "R10 status read", reg_rdata, exp_rd);
        check(irq == exp_irq(txq.size(), rxq.size(), eos, m_en_tx, m_en_rx),
              "R5/R6/R7/R9/R11 irq", 32'(irq),
              32'(exp_irq(txq.size(), rxq.size(), eos, m_en_tx, m_en_rx)));
    endtask

    task automatic idle(input bit eos);
        step(1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 8'd0, eos);
    endtask

    task automatic rd_status(input bit eos);
        step(1'b0, 1'b1, 2'd2, 8'd0, 1'b0, 1'b0, 8'd0, eos);
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        check(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
        check(host_tx_valid == 1'b0, "R1 tx valid", 32'(host_tx_valid), 32'd0);
        check(reg_rdata == 32'd0, "R1 rdata", reg_rdata, 32'd0);
        rd_status(1'b0);
        step(1'b0, 1'b1, 2'd1, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0);

        // R8/R9: enable only transmit; empty FIFO is pending
        step(1'b1, 1'b0, 2'd1, 8'h01, 1'b0, 1'b0, 8'd0, 1'b0);
        check(irq == 1'b1, "R9 tx irq empty", 32'(irq), 32'd1);
        step(1'b0, 1'b1, 2'd1, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0);

        // R5: walk across the transmit threshold, then past full
        for (int i = 0; i < DEPTH + 2; i++) begin
            step(1'b1, 1'b0, 2'd0, 8'(8'h40 + i), 1'b0, 1'b0, 8'd0, 1'b0);
            if (i == WR_THR - 1) check(irq == 1'b1, "R5 at threshold", 32'(irq), 32'd1);
            if (i == WR_THR)     check(irq == 1'b0, "R5 above threshold", 32'(irq), 32'd0);
        end
        rd_status(1'b0);
        // R4: push and pop together on a full FIFO
        step(1'b1, 1'b0, 2'd0, 8'hEE, 1'b1, 1'b0, 8'd0, 1'b0);
        // R10: writes to status and unused address are ignored
        step(1'b1, 1'b0, 2'd2, 8'hFF, 1'b0, 1'b0, 8'd0, 1'b0);
        step(1'b1, 1'b0, 2'd3, 8'hFF, 1'b0, 1'b0, 8'd0, 1'b0);
        rd_status(1'b0);
        step(1'b0, 1'b1, 2'd3, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0);
        // R2: drain past empty
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 8'd0, 1'b0);
        // R4: push and pop together on an empty FIFO
        step(1'b1, 1'b0, 2'd0, 8'h5A, 1'b1, 1'b0, 8'd0, 1'b0);
        step(1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 8'd0, 1'b0);

        // R6: enable only receive, fill across the threshold and past full
        step(1'b1, 1'b0, 2'd0 + 2'd1, 8'h02, 1'b0, 1'b0, 8'd0, 1'b0);
        for (int i = 0; i < DEPTH + 2; i++) begin
            step(1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b1, 8'(8'h80 + i), 1'b0);
            if (i == DEPTH - RD_THR - 2) check(irq == 1'b0, "R6 below threshold", 32'(irq), 32'd0);
            if (i == DEPTH - RD_THR - 1) check(irq == 1'b1, "R6 at threshold", 32'(irq), 32'd1);
        end
        rd_status(1'b0);
        // R4: host push with a processor pop on a full receive FIFO
        step(1'b0, 1'b1, 2'd0, 8'd0, 1'b0, 1'b1, 8'hC3, 1'b0);
        // R3: drain past empty
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b1, 2'd0, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0);
        rd_status(1'b0);
        // R4: push and pop together on an empty receive FIFO
        step(1'b0, 1'b1, 2'd0, 8'd0, 1'b0, 1'b1, 8'h3C, 1'b0);

        // R7: one character plus end-of-stream raises the receive pend
        idle(1'b0);
        check(irq == 1'b0, "R7 no eos", 32'(irq), 32'd0);
        idle(1'b1);
        check(irq == 1'b1, "R7 eos with data", 32'(irq), 32'd1);
        rd_status(1'b1);
        step(1'b0, 1'b1, 2'd0, 8'd0, 1'b0, 1'b0, 8'd0, 1'b1);
        check(irq == 1'b0, "R7 eos but empty", 32'(irq), 32'd0);

        // Random phases biased toward filling or draining each side
        for (int i = 0; i < 4000; i++) begin
            int phase;
            int pw;
            int pr;
            bit wr;
            bit rd;
            logic [1:0] addr;
            phase = (i / 250) % 4;
            pw = (phase == 0) ? 80 : (phase == 1) ? 15 : 45;
            pr = (phase == 2) ? 15 : (phase == 3) ? 80 : 45;
            wr = 1'b0; rd = 1'b0;
            addr = ($urandom_range(0, 99) < 80) ? 2'd0 : 2'($urandom_range(1, 3));
            if ($urandom_range(0, 1) == 0) wr = ($urandom_range(0, 99) < pw);
            else                            rd = ($urandom_range(0, 99) < pr) || (addr != 2'd0);
            if (wr && addr == 2'd0 && (phase == 1)) wr = ($urandom_range(0, 3) == 0);
            step(wr, rd, addr, 8'($urandom),
                 ($urandom_range(0, 99) < ((phase == 0) ? 20 : 55)),
                 ($urandom_range(0, 99) < ((phase == 2) ? 85 : (phase == 3) ? 20 : 50)),
                 8'($urandom), ((i / 90) % 3) == 2);
        end
        idle(1'b0);
        rd_status(1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule